// File: doc/BRIEF.md
# Six-Channel Staggered PWM Generator

This block turns one duty-cycle word into six LED-enable pulse trains. A single free-running period counter sets the PWM period. Each channel compares its own view of that counter against a duty value. With staggering enabled, each channel's view is offset so that its pulse starts a fixed fraction of the period after its lower-numbered neighbour. This spreads the turn-on edges evenly across the period, so the supply sees a smaller load peak.

The comparator width can be chosen at run time, from 8 to 13 bits, and the period is always two to the power of that width. The 13-bit duty word is cut down to the chosen width by keeping its upper bits. New duty, width and stagger settings take effect only at a period boundary. A per-channel mask can pin any output fully on. A bypass mode makes all six outputs follow a synchronised copy of an external PWM pin. A one-cycle strobe marks each period start, so that a downstream dither stage can step its pulse index.

Top module: `led_pwm_stagger`

## Requirements
- R1: With stagger off and bypass off, every channel not masked on shows the same level in every cycle.
- R2: With stagger on, channel n turns on floor(n * 2^w / 6) cycles after channel 0 within the period, where w is the active width. Here n runs from 0 to 5.
- R3: `res_sel_i` value s selects width w = 8 + s for s from 0 to 5, and any larger value selects 13. The period is 2^w clock cycles, and the period counter never passes 2^w - 1.
- R4: The value compared is `duty_i[12 -: w]`, the upper w bits of the 13-bit word. Each channel is high for exactly that many cycles per period.
- R5: A compared value of 0 keeps a channel low for the whole period. A compared value of 2^w - 1 (all ones) keeps it high for the whole period.
- R6: When bit n of `force_i` is set, `ch_o[n]` is high from the cycle after the bit is sampled. This holds in both PWM mode and bypass mode.
- R7: When `direct_i` is 1, all six outputs equal `pwm_pin_i` as sampled three clock edges earlier (two synchroniser stages plus the output register), with no stagger applied.
- R8: `duty_i`, `res_sel_i` and `ps_en_i` are sampled only at the last cycle of a period. A change made mid-period alters neither the high time nor the length of the period in progress.
- R9: `period_start_o` is high for exactly one cycle per period, in the cycle where channel 0 shows count 0 of its period. Consecutive strobes are 2^w cycles apart.
- R10: During reset all outputs are low. After reset the width is 8 bits and the duty is 0, so every channel stays low until a new duty value is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| duty_i | input | 13 | Duty word, most significant bit aligned |
| res_sel_i | input | 3 | Comparator width select (8 + value, clamped at 13) |
| ps_en_i | input | 1 | Enable the one-sixth stagger between channels |
| force_i | input | 6 | Per-channel mask forcing the output fully on |
| direct_i | input | 1 | Bypass: outputs follow the synchronised PWM pin |
| pwm_pin_i | input | 1 | Raw external PWM input, may be asynchronous |
| ch_o | output | 6 | Channel enable outputs |
| period_start_o | output | 1 | One-cycle strobe at the start of each period |

## Verification
The properties treat `force_i` and `direct_i` as synchronous controls sampled at each rising edge, and check them only once enough edges have passed since reset to fill the synchroniser. `pwm_pin_i` is treated as a free level that may change in any cycle. The lockstep property relies on the rule that stagger changes take effect only at a period boundary. For that reason the stimulus changes duty, width and stagger only at falling edges, and measures a period only after two full periods have passed since the last change. Bypass and mask changes are applied on falling edges while the duty is zero, so any level seen at an output comes from the path under test.

// File: rtl/led_pwm_stagger_pkg.sv
package led_pwm_stagger_pkg;
  localparam int unsigned DefNumCh      = 6;
  localparam int unsigned DefMinRes     = 8;
  localparam int unsigned DefMaxRes     = 13;
  localparam int unsigned DefSyncStages = 2;

  function automatic int unsigned sel_to_res(input int unsigned sel,
                                             input int unsigned min_res,
                                             input int unsigned max_res);
    return (sel > max_res - min_res) ? max_res : min_res + sel;
  endfunction
endpackage

// File: rtl/led_pwm_period_ctr.sv
module led_pwm_period_ctr
  import led_pwm_stagger_pkg::*;
#(
  parameter int unsigned MIN_RES = DefMinRes,
  parameter int unsigned MAX_RES = DefMaxRes,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned RES_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MAX_RES-1:0] duty_i,
  input  logic [SEL_W-1:0]   res_sel_i,
  input  logic               ps_en_i,
  output logic [MAX_RES-1:0] cnt_o,
  output logic [MAX_RES-1:0] mask_o,
  output logic [RES_W-1:0]   res_o,
  output logic               ps_o,
  output logic               wrap_o,
  output logic               start_o,
  output logic [MAX_RES:0]   duty_cur_o,
  output logic [MAX_RES:0]   duty_new_o
);
  logic [MAX_RES-1:0] cnt_q;
  logic [RES_W-1:0]   res_q, res_new, shamt;
  logic               ps_q, start_q;
  logic [MAX_RES:0]   duty_q, span_cur, span_new, duty_red;

  always_comb begin
    res_new    = RES_W'(sel_to_res(32'(res_sel_i), MIN_RES, MAX_RES));
    shamt      = RES_W'(MAX_RES) - res_new;
    span_cur   = (MAX_RES+1)'(1) << res_q;
    span_new   = (MAX_RES+1)'(1) << res_new;
    mask_o     = span_cur[MAX_RES-1:0] - MAX_RES'(1);
    duty_red   = {1'b0, duty_i >> shamt};
    // all ones at the new width maps to a full period
    duty_new_o = (duty_red == span_new - (MAX_RES+1)'(1)) ? span_new : duty_red;
    wrap_o     = (cnt_q == mask_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      res_q   <= RES_W'(MIN_RES);
      ps_q    <= 1'b0;
      duty_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= (cnt_q == '0);
      if (wrap_o) begin
        cnt_q  <= '0;
        res_q  <= res_new;
        ps_q   <= ps_en_i;
        duty_q <= duty_new_o;
      end else begin
        cnt_q <= cnt_q + MAX_RES'(1);
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign res_o      = res_q;
  assign ps_o       = ps_q;
  assign start_o    = start_q;
  assign duty_cur_o = duty_q;
endmodule

// File: rtl/led_pwm_chan.sv
module led_pwm_chan #(
  parameter  int unsigned IDX     = 0,
  parameter  int unsigned NUM_CH  = 6,
  parameter  int unsigned MAX_RES = 13,
  parameter  int unsigned RES_W   = 4,
  localparam int unsigned OFF_W   = MAX_RES + $clog2(NUM_CH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MAX_RES-1:0] cnt_i,
  input  logic [MAX_RES-1:0] mask_i,
  input  logic [RES_W-1:0]   res_i,
  input  logic               ps_i,
  input  logic               ps_en_i,
  input  logic               wrap_i,
  input  logic [MAX_RES:0]   duty_cur_i,
  input  logic [MAX_RES:0]   duty_new_i,
  output logic               pwm_o
);
  logic [OFF_W-1:0]   off_full;
  logic [MAX_RES-1:0] off, lcnt;
  logic [MAX_RES:0]   duty_q;
  logic               ch_wrap, load;

  always_comb begin
    off_full = (OFF_W'(IDX) << res_i) / OFF_W'(NUM_CH);
    off      = ps_i ? off_full[MAX_RES-1:0] : '0;
    lcnt     = (cnt_i - off) & mask_i;
    ch_wrap  = (lcnt == mask_i);
    // leaving stagger mode realigns every channel at the shared boundary
    load     = ch_wrap | (wrap_i & ~ps_en_i);
    pwm_o    = ({1'b0, lcnt} < duty_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   duty_q <= '0;
    else if (load) duty_q <= wrap_i ? duty_new_i : duty_cur_i;
  end
endmodule

// File: rtl/led_pwm_pin_sync.sv
module led_pwm_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], pin_i};
  end

  assign pin_o = sync_q[STAGES-1];
endmodule

// File: rtl/led_pwm_stagger.sv
module led_pwm_stagger
  import led_pwm_stagger_pkg::*;
#(
  parameter  int unsigned NUM_CH      = DefNumCh,
  parameter  int unsigned MIN_RES     = DefMinRes,
  parameter  int unsigned MAX_RES     = DefMaxRes,
  parameter  int unsigned SYNC_STAGES = DefSyncStages,
  localparam int unsigned SEL_W       = $clog2(MAX_RES - MIN_RES + 1),
  localparam int unsigned RES_W       = $clog2(MAX_RES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MAX_RES-1:0] duty_i,
  input  logic [SEL_W-1:0]   res_sel_i,
  input  logic               ps_en_i,
  input  logic [NUM_CH-1:0]  force_i,
  input  logic               direct_i,
  input  logic               pwm_pin_i,
  output logic [NUM_CH-1:0]  ch_o,
  output logic               period_start_o
);
  logic [MAX_RES-1:0] cnt_w, mask_w;
  logic [RES_W-1:0]   res_w;
  logic               ps_w, wrap_w, start_w, pin_s;
  logic [MAX_RES:0]   duty_cur_w, duty_new_w;
  logic [NUM_CH-1:0]  pwm_w, ch_q;

  led_pwm_period_ctr #(
    .MIN_RES(MIN_RES), .MAX_RES(MAX_RES), .SEL_W(SEL_W), .RES_W(RES_W)
  ) i_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .duty_i     (duty_i),
    .res_sel_i  (res_sel_i),
    .ps_en_i    (ps_en_i),
    .cnt_o      (cnt_w),
    .mask_o     (mask_w),
    .res_o      (res_w),
    .ps_o       (ps_w),
    .wrap_o     (wrap_w),
    .start_o    (start_w),
    .duty_cur_o (duty_cur_w),
    .duty_new_o (duty_new_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    led_pwm_chan #(
      .IDX(g), .NUM_CH(NUM_CH), .MAX_RES(MAX_RES), .RES_W(RES_W)
    ) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_i      (cnt_w),
      .mask_i     (mask_w),
      .res_i      (res_w),
      .ps_i       (ps_w),
      .ps_en_i    (ps_en_i),
      .wrap_i     (wrap_w),
      .duty_cur_i (duty_cur_w),
      .duty_new_i (duty_new_w),
      .pwm_o      (pwm_w[g])
    );
  end

  led_pwm_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pwm_pin_i),
    .pin_o  (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ch_q <= '0;
    else         ch_q <= force_i | (direct_i ? {NUM_CH{pin_s}} : pwm_w);
  end

  assign ch_o           = ch_q;
  assign period_start_o = start_w;
endmodule

// File: rtl/led_pwm_stagger_chk.sv
module led_pwm_stagger_chk #(
  parameter int unsigned NUM_CH      = 6,
  parameter int unsigned MAX_RES     = 13,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_CH-1:0]  force_i,
  input logic               direct_i,
  input logic               pwm_pin_i,
  input logic [NUM_CH-1:0]  ch_o,
  input logic               period_start_o,
  input logic               ps_i,
  input logic [MAX_RES-1:0] cnt_i,
  input logic [MAX_RES-1:0] mask_i
);
  logic [3:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 4'hF)   age_q <= age_q + 4'd1;
  end

  AST_FORCE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 4'd0) |-> ((ch_o & $past(force_i)) == $past(force_i))); // R6

  AST_DIRECT_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q > 4'(SYNC_STAGES) && $past(direct_i)) |->
    (ch_o == ({NUM_CH{$past(pwm_pin_i, SYNC_STAGES+1)}} | $past(force_i)))); // R7

  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |=> !period_start_o); // R9

  AST_LOCKSTEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 4'd0 && $past(!direct_i && !ps_i)) |->
    (((ch_o & ~$past(force_i)) == '0) || ((ch_o | $past(force_i)) == '1))); // R1

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= mask_i); // R3
endmodule

bind led_pwm_stagger led_pwm_stagger_chk #(
  .NUM_CH(NUM_CH), .MAX_RES(MAX_RES), .SYNC_STAGES(SYNC_STAGES)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .force_i        (force_i),
  .direct_i       (direct_i),
  .pwm_pin_i      (pwm_pin_i),
  .ch_o           (ch_o),
  .period_start_o (period_start_o),
  .ps_i           (ps_w),
  .cnt_i          (cnt_w),
  .mask_i         (mask_w)
);

// File: tb/test_led_pwm_stagger.sv
`timescale 1ns/1ps
module test_led_pwm_stagger;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] duty = '0;
  logic [2:0]  res_sel = '0;
  logic        ps_en = 1'b0;
  logic [5:0]  force_m = '0;
  logic        direct = 1'b0;
  logic        pin = 1'b0;
  logic [5:0]  ch;
  logic        strobe;

  always #2 clk = ~clk;

  led_pwm_stagger i_led_pwm_stagger (
    .clk_i(clk), .rst_ni(rst_n), .duty_i(duty), .res_sel_i(res_sel),
    .ps_en_i(ps_en), .force_i(force_m), .direct_i(direct), .pwm_pin_i(pin),
    .ch_o(ch), .period_start_o(strobe)
  );

  int n_tests = 0;
  int n_fails = 0;
  bit finished = 0;
  int hi_cnt[NCH];
  int first_hi[NCH];
  int strobe_hits;
  bit uneq;
  bit end_strobe;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_strobe();
    @(negedge clk);
    while (strobe !== 1'b1) @(negedge clk);
  endtask

  task automatic apply(input logic [12:0] d, input logic [2:0] s, input logic p);
    @(negedge clk);
    duty = d; res_sel = s; ps_en = p;
  endtask

  task automatic settle();
    wait_strobe();
    wait_strobe();
  endtask

  // samples one period starting at a strobe cycle
  task automatic measure(input int p);
    for (int c = 0; c < NCH; c++) begin hi_cnt[c] = 0; first_hi[c] = -1; end
    strobe_hits = 0; uneq = 0;
    wait_strobe();
    for (int k = 0; k < p; k++) begin
      if (k > 0) @(negedge clk);
      if (strobe) strobe_hits++;
      if (!(ch == 6'h00 || ch == 6'h3F)) uneq = 1;
      for (int c = 0; c < NCH; c++)
        if (ch[c]) begin
          hi_cnt[c]++;
          if (first_hi[c] < 0) first_hi[c] = k;
        end
    end
    @(negedge clk);
    end_strobe = strobe;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ch == 6'h00, "R10 outputs low in reset", int'(ch), 0);
    check(strobe == 1'b0, "R10 strobe low in reset", int'(strobe), 0);
    rst_n = 1'b1;
    measure(256);
    check(hi_cnt[0] == 0 && hi_cnt[5] == 0, "R10 zero duty after reset", hi_cnt[0] + hi_cnt[5], 0);
    check(end_strobe && strobe_hits == 1, "R10 default 8-bit period", strobe_hits, 1);
  endtask

  task automatic test_basic();
    apply(13'(64 << 5), 3'd0, 1'b0);
    settle();
    measure(256);
    for (int c = 0; c < NCH; c++) check(hi_cnt[c] == 64, "R4 high count d=64", hi_cnt[c], 64);
    check(!uneq, "R1 channels in lockstep", int'(uneq), 0);
    check(strobe_hits == 1 && end_strobe, "R9 single strobe per 256 cycles", strobe_hits, 1);
    apply(13'h0A5F, 3'd0, 1'b0);
    settle();
    measure(256);
    check(hi_cnt[0] == 82, "R4 upper bits kept 0x0A5F", hi_cnt[0], 82);
    check(!uneq, "R1 lockstep second pattern", int'(uneq), 0);
  endtask

  task automatic test_extremes();
    apply(13'h001F, 3'd0, 1'b0);
    settle();
    measure(256);
    check(hi_cnt[0] == 0 && hi_cnt[3] == 0, "R5 zero after truncation", hi_cnt[0], 0);
    apply(13'h1FFF, 3'd0, 1'b0);
    settle();
    measure(256);
    check(hi_cnt[0] == 256 && hi_cnt[4] == 256, "R5 all ones full on", hi_cnt[0], 256);
    apply(13'h1FDF, 3'd0, 1'b0);
    settle();
    measure(256);
    check(hi_cnt[0] == 254, "R5 one below full", hi_cnt[0], 254);
  endtask

  task automatic test_phase(input logic [2:0] s, input int p, input logic [12:0] d, input int dexp);
    apply(d, s, 1'b1);
    settle();
    measure(p);
    for (int c = 0; c < NCH; c++) begin
      check(first_hi[c] == (c * p) / 6, "R2 stagger offset", first_hi[c], (c * p) / 6);
      check(hi_cnt[c] == dexp, "R2 staggered high count", hi_cnt[c], dexp);
    end
    check(strobe_hits == 1 && end_strobe, "R3 period length", strobe_hits, 1);
  endtask

  task automatic test_clamp();
    apply(13'h1000, 3'd7, 1'b0);
    settle();
    measure(8192);
    check(hi_cnt[0] == 4096, "R3 select 7 gives 13 bits", hi_cnt[0], 4096);
    check(strobe_hits == 1 && end_strobe, "R3 13-bit period 8192", strobe_hits, 1);
  endtask

  task automatic test_boundary();
    int cnt0;
    apply(13'(64 << 5), 3'd0, 1'b0);
    settle();
    wait_strobe();
    cnt0 = 0;
    for (int k = 0; k < 256; k++) begin
      if (k > 0) @(negedge clk);
      if (ch[0]) cnt0++;
      if (k == 100) begin duty = 13'h1900; res_sel = 3'd2; end
    end
    check(cnt0 == 64, "R8 mid-period duty change ignored", cnt0, 64);
    @(negedge clk);
    check(strobe == 1'b1, "R8 mid-period width change ignored", int'(strobe), 1);
    cnt0 = 0;
    for (int k = 0; k < 1024; k++) begin
      if (k > 0) @(negedge clk);
      if (ch[0]) cnt0++;
    end
    check(cnt0 == 800, "R8 new values at next period", cnt0, 800);
    @(negedge clk);
    check(strobe == 1'b1, "R9 strobe after 1024 cycles", int'(strobe), 1);
    apply(13'h0000, 3'd0, 1'b0);
    settle();
  endtask

  task automatic test_force();
    @(negedge clk);
    force_m = 6'b100101;
    @(negedge clk);
    check(ch == 6'b100101, "R6 force mask applied", int'(ch), 6'b100101);
    repeat (20) @(negedge clk);
    check(ch == 6'b100101, "R6 force mask held", int'(ch), 6'b100101);
    force_m = 6'b000000;
    @(negedge clk);
    check(ch == 6'h00, "R6 force released", int'(ch), 0);
  endtask

  task automatic test_direct();
    @(negedge clk);
    direct = 1'b1; ps_en = 1'b1; pin = 1'b0;
    repeat (4) @(negedge clk);
    check(ch == 6'h00, "R7 bypass pin low", int'(ch), 0);
    pin = 1'b1;
    @(negedge clk);
    check(ch == 6'h00, "R7 latency edge 1", int'(ch), 0);
    @(negedge clk);
    check(ch == 6'h00, "R7 latency edge 2", int'(ch), 0);
    @(negedge clk);
    check(ch == 6'h3F, "R7 all follow pin, no stagger", int'(ch), 63);
    pin = 1'b0;
    repeat (3) @(negedge clk);
    check(ch == 6'h00, "R7 pin low again", int'(ch), 0);
    force_m = 6'b000010;
    @(negedge clk);
    check(ch == 6'b000010, "R6 force in bypass", int'(ch), 2);
    force_m = 6'b000000; direct = 1'b0; ps_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    test_reset();
    test_basic();
    test_extremes();
    test_phase(3'd0, 256, 13'(32 << 5), 32);
    test_phase(3'd2, 1024, 13'(64 << 3), 64);
    test_clamp();
    test_boundary();
    test_force();
    test_direct();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fails++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
      $finish;
    end
  end
endmodule